// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block gathers the four interrupt causes of one serial port channel (receive, error, transmit and modem) into a single level-sensitive request line. It keeps a source register that latches each cause, a mask register that silences chosen causes, and a pending register holding the unmasked causes. Software reaches all three, plus a small FIFO control word, through a simple single-cycle register port. The receive and transmit datapath supply one-cycle set pulses and the current transmit FIFO fill count.

The transmit cause can also come from the fill level. Whenever the pending view is re-evaluated and FIFO mode is on, the transmit source bit is set if the transmit fill count is at or below a threshold. The threshold is the 3-bit transmit trigger field scaled by a factor fixed per channel at elaboration time. The pending register is not recomputed every cycle. It is refreshed only on an update event: a set pulse, a transmit data write, a pending write or a mask write. A write to the source register alone leaves it as it was.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source, pending, mask and FIFO control registers read 0 and `irq` is low.
- R2: A pulse on `rx_set`, `err_set` or `modem_set` sets source bit 0, 1 or 3 respectively.
- R3: On every update event the pending register becomes source AND NOT mask. `irq` is high exactly when pending is nonzero.
- R4: Writing the mask register (address 3, bits [3:0]) is an update event. A masked source therefore never appears in pending.
- R5: A write to the pending register (address 2) clears, write-1-to-clear, the written bits in both pending and source, and then re-evaluates pending.
- R6: A write to the source register (address 1) clears the written-1 bits of source only. Pending and `irq` keep their previous values until the next update event.
- R7: A write to the transmit data address (address 4) sets source bit 2, whatever the data.
- R8: On an update event with FIFO control bit 0 set, source bit 2 is set when `tx_count` is less than or equal to the trigger level. With bit 0 clear, the fill level sets nothing.
- R9: The trigger level is FIFO control bits [10:8] times 32 on channel 0, times 8 on channels 1 and 4, and times 2 on channels 2 and 3. It is 0 on any other channel.
- R10: When a set pulse or transmit data write and a clear write hit the same source bit in one cycle, the bit ends up set.
- R11: FIFO control (address 0) keeps bits [10:8], [6:4] and [0] and reads every other bit as 0. The receive trigger field at [6:4] has no effect on interrupts.
- R12: A read strobe returns the addressed register on `bus_rdata` one cycle later. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| rx_set | input | 1 | Receive cause pulse |
| err_set | input | 1 | Error cause pulse |
| modem_set | input | 1 | Modem cause pulse |
| tx_count | input | TXCNT_W | Transmit FIFO fill count |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are those where pending and source disagree. A source write must leave a stale pending value and a live `irq` behind, and that difference shows only if nothing else triggers a re-evaluation before it is read. The bench first reads back the stale state, then forces a mask write to prove the refresh. The fill-level threshold is probed at exactly the level, one above it and at the top field value. A second instance built for a different channel sees the same stimulus, so that one `tx_count` lands on opposite sides of the two thresholds.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NSRC    = 4;
   localparam int SRC_RX  = 0;
   localparam int SRC_ERR = 1;
   localparam int SRC_TX  = 2;
   localparam int SRC_MDM = 3;

   localparam int TRIG_W  = 3;

   // FIFO control field positions
   localparam int FC_EN     = 0;
   localparam int FC_RXT_LO = 4;
   localparam int FC_TXT_LO = 8;

   typedef enum logic [2:0] {
      SEL_FCTL = 3'd0,
      SEL_SRC  = 3'd1,
      SEL_PEND = 3'd2,
      SEL_MASK = 3'd3,
      SEL_TXD  = 3'd4
   } reg_sel_e;

   // log2 of the per-channel trigger multiplier, -1 when the channel has none
   function automatic int chan_shift(input int ch);
      case (ch)
         0:       return 5;
         1, 4:    return 3;
         2, 3:    return 1;
         default: return -1;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [2:0]          bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NSRC-1:0]     src,
   input  logic [NSRC-1:0]     pend,
   output logic                wr_src,
   output logic                wr_pend,
   output logic                wr_mask,
   output logic                wr_txd,
   output logic [NSRC-1:0]     wval,
   output logic [NSRC-1:0]     mask_next,
   output logic [NSRC-1:0]     mask,
   output logic                fifo_en,
   output logic [TRIG_W-1:0]   tx_trig
);

   logic [TRIG_W-1:0] rx_trig;
   logic [DATA_W-1:0] rd_mux;
   reg_sel_e          sel;

   assign sel     = reg_sel_e'(bus_addr);
   assign wr_src  = bus_wr && (sel == SEL_SRC);
   assign wr_pend = bus_wr && (sel == SEL_PEND);
   assign wr_mask = bus_wr && (sel == SEL_MASK);
   assign wr_txd  = bus_wr && (sel == SEL_TXD);
   assign wval    = bus_wdata[NSRC-1:0];

   assign mask_next = wr_mask ? wval : mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask    <= '0;
         fifo_en <= 1'b0;
         tx_trig <= '0;
         rx_trig <= '0;
      end else begin
         mask <= mask_next;
         if (bus_wr && (sel == SEL_FCTL)) begin
            fifo_en <= bus_wdata[FC_EN];
            tx_trig <= bus_wdata[FC_TXT_LO +: TRIG_W];
            rx_trig <= bus_wdata[FC_RXT_LO +: TRIG_W];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_FCTL: begin
            rd_mux[FC_EN]               = fifo_en;
            rd_mux[FC_TXT_LO +: TRIG_W] = tx_trig;
            rd_mux[FC_RXT_LO +: TRIG_W] = rx_trig;
         end
         SEL_SRC:  rd_mux[NSRC-1:0] = src;
         SEL_PEND: rd_mux[NSRC-1:0] = pend;
         SEL_MASK: rd_mux[NSRC-1:0] = mask;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   // R11: a FIFO control write is not a mask write
   p_fctl_keeps_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_FCTL) |=> $stable(mask));

endmodule

// File: rtl/uart_irq_txlvl.sv
module uart_irq_txlvl
   import uart_irq_pkg::*;
#(
   parameter int CHANNEL = 0,
   parameter int CNT_W   = 8
) (
   input  logic [TRIG_W-1:0] tx_trig,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              fifo_en,
   output logic              lvl_hit
);

   localparam int SHIFT  = chan_shift(CHANNEL);
   localparam int LVL_W  = TRIG_W + ((SHIFT > 0) ? SHIFT : 0);
   localparam int CMP_W  = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;

   logic [CMP_W-1:0] level;
   logic [CMP_W-1:0] cnt_ext;

   generate
      if (SHIFT >= 0) begin : g_scaled
         assign level = CMP_W'(tx_trig) << SHIFT;
      end else begin : g_none
         assign level = '0;
      end
   endgenerate

   assign cnt_ext = CMP_W'(tx_count);
   assign lvl_hit = fifo_en && (cnt_ext <= level);

endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
   import uart_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic [NSRC-1:0] clr,
   input  logic            upd,
   input  logic [NSRC-1:0] mask_next,
   input  logic [NSRC-1:0] mask,
   output logic [NSRC-1:0] src,
   output logic [NSRC-1:0] pend
);

   logic [NSRC-1:0] src_next;

   // set wins over clear on the same bit
   assign src_next = (src & ~clr) | set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src  <= '0;
         pend <= '0;
      end else begin
         src <= src_next;
         if (upd) pend <= src_next & ~mask_next;
      end
   end

   p_pend_recalc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (pend == (src & ~mask)));

   p_pend_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && |clr) |=> ((pend & $past(clr & ~set)) == '0));

   p_src_only_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(pend));

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((src & $past(set)) == $past(set)));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int CHANNEL = 0,
   parameter int DATA_W  = 32,
   parameter int TXCNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [2:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               rx_set,
   input  logic               err_set,
   input  logic               modem_set,
   input  logic [TXCNT_W-1:0] tx_count,
   output logic               irq
);

   generate
      if (DATA_W < FC_TXT_LO + TRIG_W) begin : g_bad_dw
         $error("DATA_W too narrow for FIFO control");
      end
      if (TXCNT_W < 1) begin : g_bad_cw
         $error("TXCNT_W must be positive");
      end
      if (CHANNEL < 0) begin : g_bad_ch
         $error("CHANNEL must be non-negative");
      end
   endgenerate

   logic                wr_src, wr_pend, wr_mask, wr_txd;
   logic [NSRC-1:0]     wval, mask, mask_next, src, pend, set, clr;
   logic                fifo_en, lvl_hit, upd, any_pulse;
   logic [TRIG_W-1:0]   tx_trig;

   uart_irq_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src(src), .pend(pend),
      .wr_src(wr_src), .wr_pend(wr_pend), .wr_mask(wr_mask), .wr_txd(wr_txd),
      .wval(wval), .mask_next(mask_next), .mask(mask),
      .fifo_en(fifo_en), .tx_trig(tx_trig)
   );

   uart_irq_txlvl #(.CHANNEL(CHANNEL), .CNT_W(TXCNT_W)) u_txlvl (
      .tx_trig(tx_trig), .tx_count(tx_count),
      .fifo_en(fifo_en), .lvl_hit(lvl_hit)
   );

   assign any_pulse = rx_set | err_set | modem_set;
   assign upd       = any_pulse | wr_txd | wr_pend | wr_mask;

   always_comb begin
      set          = '0;
      set[SRC_RX]  = rx_set;
      set[SRC_ERR] = err_set;
      set[SRC_MDM] = modem_set;
      set[SRC_TX]  = wr_txd | (upd & lvl_hit);
   end

   assign clr = (wr_src | wr_pend) ? wval : '0;

   uart_irq_core u_core (
      .clk(clk), .rst_n(rst_n),
      .set(set), .clr(clr), .upd(upd),
      .mask_next(mask_next), .mask(mask),
      .src(src), .pend(pend)
   );

   assign irq = |pend;

   p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & mask) == '0));

   p_txd_sets_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txd |=> src[SRC_TX]);

   p_rx_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_set |=> src[SRC_RX]);

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

   localparam int DW = 32;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] rdata0, rdata1;
   logic          rx_set = 1'b0, err_set = 1'b0, modem_set = 1'b0;
   logic [CW-1:0] tx_count = '0;
   logic          irq0, irq1;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ctrl #(.CHANNEL(0), .DATA_W(DW), .TXCNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
      .rx_set(rx_set), .err_set(err_set), .modem_set(modem_set),
      .tx_count(tx_count), .irq(irq0)
   );

   uart_irq_ctrl #(.CHANNEL(3), .DATA_W(DW), .TXCNT_W(CW)) dut_ch3 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
      .rx_set(rx_set), .err_set(err_set), .modem_set(modem_set),
      .tx_count(tx_count), .irq(irq1)
   );

   typedef struct {
      string       req;
      logic [31:0] e0;
      logic [31:0] e1;
   } exp_t;

   exp_t exp_q[$];
   logic rd_d = 1'b0;

   always @(posedge clk) rd_d <= bus_rd & rst_n;

   // monitor: pops the expected item when the read data returns
   always @(negedge clk) begin
      if (rd_d) begin
         if (exp_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R12: read data with no expected item");
         end else begin
            exp_t it;
            it = exp_q.pop_front();
            n_tests++;
            if (rdata0 !== it.e0) begin
               n_fail++;
               $display("FAIL %s ch0: got %h expected %h", it.req, rdata0, it.e0);
            end
            n_tests++;
            if (rdata1 !== it.e1) begin
               n_fail++;
               $display("FAIL %s ch3: got %h expected %h", it.req, rdata1, it.e1);
            end
         end
      end
   end

   task automatic rd_exp(input string req, input logic [2:0] a,
                         input logic [31:0] e0, input logic [31:0] e1);
      exp_t it;
      it.req = req; it.e0 = e0; it.e1 = e1;
      exp_q.push_back(it);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic pulse(input logic r, input logic e, input logic m);
      @(negedge clk); rx_set = r; err_set = e; modem_set = m;
      @(negedge clk); rx_set = 0; err_set = 0; modem_set = 0;
   endtask

   task automatic chk_irq(input string req, input logic e0, input logic e1);
      n_tests++;
      if (irq0 !== e0 || irq1 !== e1) begin
         n_fail++;
         $display("FAIL %s irq: got %b/%b expected %b/%b", req, irq0, irq1, e0, e1);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_irq("R1", 0, 0);
      rd_exp("R1", 3'd0, 0, 0);
      rd_exp("R1", 3'd1, 0, 0);
      rd_exp("R1", 3'd2, 0, 0);
      rd_exp("R1", 3'd3, 0, 0);
      rd_exp("R12", 3'd6, 0, 0);

      // R2 bit positions
      pulse(1, 0, 0);
      chk_irq("R2", 1, 1);
      rd_exp("R2", 3'd1, 32'h1, 32'h1);
      pulse(0, 1, 0);
      pulse(0, 0, 1);
      rd_exp("R2", 3'd1, 32'hB, 32'hB);
      rd_exp("R3", 3'd2, 32'hB, 32'hB);

      // R5 pending W1C clears both
      wr(3'd2, 32'h3);
      rd_exp("R5", 3'd1, 32'h8, 32'h8);
      rd_exp("R5", 3'd2, 32'h8, 32'h8);
      chk_irq("R5", 1, 1);

      // R4 mask write
      wr(3'd3, 32'h8);
      chk_irq("R4", 0, 0);
      rd_exp("R4", 3'd2, 0, 0);
      rd_exp("R4", 3'd3, 32'h8, 32'h8);
      wr(3'd3, 32'h0);
      chk_irq("R4", 1, 1);

      // R6 source write leaves pending stale
      wr(3'd1, 32'h8);
      rd_exp("R6", 3'd1, 0, 0);
      rd_exp("R6", 3'd2, 32'h8, 32'h8);
      chk_irq("R6", 1, 1);
      wr(3'd3, 32'h0);
      chk_irq("R3", 0, 0);
      rd_exp("R3", 3'd2, 0, 0);

      // R7 transmit data write
      wr(3'd4, 32'h0);
      rd_exp("R7", 3'd1, 32'h4, 32'h4);
      chk_irq("R7", 1, 1);
      wr(3'd2, 32'hF);

      // R8/R9 fill level
      tx_count = 8'd40;
      wr(3'd0, 32'h101);
      rd_exp("R11", 3'd0, 32'h101, 32'h101);
      pulse(0, 1, 0);
      rd_exp("R8", 3'd1, 32'h2, 32'h2);
      wr(3'd2, 32'h2);
      tx_count = 8'd3;
      pulse(1, 0, 0);
      rd_exp("R9", 3'd1, 32'h5, 32'h1);
      wr(3'd2, 32'hF);
      rd_exp("R9", 3'd1, 32'h4, 32'h0);
      chk_irq("R9", 1, 0);
      tx_count = 8'd32;
      wr(3'd2, 32'hF);
      rd_exp("R9", 3'd1, 32'h4, 32'h0);
      tx_count = 8'd2;
      wr(3'd2, 32'hF);
      rd_exp("R9", 3'd1, 32'h4, 32'h4);
      tx_count = 8'd33;
      wr(3'd2, 32'hF);
      rd_exp("R9", 3'd1, 32'h0, 32'h0);
      chk_irq("R9", 0, 0);
      wr(3'd0, 32'h701);
      tx_count = 8'd224;
      wr(3'd2, 32'hF);
      rd_exp("R9", 3'd1, 32'h4, 32'h0);
      tx_count = 8'd225;
      wr(3'd2, 32'hF);
      rd_exp("R9", 3'd1, 32'h0, 32'h0);
      // FIFO mode off: no level set
      wr(3'd0, 32'h100);
      tx_count = 8'd0;
      wr(3'd2, 32'hF);
      rd_exp("R8", 3'd1, 32'h0, 32'h0);
      chk_irq("R8", 0, 0);

      // R10 set beats clear
      @(negedge clk); rx_set = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'h1;
      @(negedge clk); rx_set = 0; bus_wr = 0;
      rd_exp("R10", 3'd2, 32'h1, 32'h1);
      @(negedge clk); bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h4;
      @(negedge clk); bus_wr = 1; bus_addr = 3'd4; bus_wdata = 32'h0;
      @(negedge clk); bus_wr = 0;
      rd_exp("R10", 3'd1, 32'h5, 32'h5);

      // R11 unused bits and receive field
      wr(3'd0, 32'hFFFF_FFFF);
      rd_exp("R11", 3'd0, 32'h771, 32'h771);
      wr(3'd2, 32'hF);
      wr(3'd0, 32'h070);
      tx_count = 8'd0;
      wr(3'd2, 32'hF);
      rd_exp("R11", 3'd1, 32'h0, 32'h0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL R12: %0d reads outstanding expected 0", exp_q.size());
      end
      done = 1'b1;
      finish_run();
   end

endmodule